// File: doc/BRIEF.md
# Addressed Serial Configuration Port

This block is the write-only configuration slave of a dual-channel voice codec. A host shifts bytes in over a three-wire link made of a serial clock, a data line and an active-low select. Several devices can share the same wires: the first byte of each transaction carries a 6-bit device address and a channel select. Only the device whose address straps match accepts the bytes that follow. Those bytes load the control register of the X or Y channel and, if the host keeps going, that channel's input and output time-slot registers. A transaction is two bytes long (address plus control) or four bytes long (address, control, input slot, output slot).

The serial lines are brought into the block's own clock domain through two-stage synchronizers. A rising serial clock is detected as an edge and gates the data bit into a byte assembler. A transaction state machine has the states IDLE, ADDR, CTRL, ITS, OTS, DONE and SKIP. The transitions are as follows. From any state the machine goes to IDLE when the select goes high or the mode pin is low. IDLE goes to ADDR when the select goes low. ADDR goes to CTRL on an address byte that matches the straps and has bit 7 clear, and goes to SKIP on any other address byte. CTRL goes to ITS, ITS to OTS and OTS to DONE, each on a complete byte. DONE and SKIP hold until the select goes high.

While the machine is between an accepted address and the end of the transaction, it raises a request to tristate the data outputs. A low mode pin selects hardware mode. In that mode the port is shut and every time-slot output reads zero.

Top module: `cfg_port`

## Requirements
- R1: A data bit is taken on each rising edge of sclk while cs_n is low, least significant bit first. Eight bits make one byte. Edges seen while cs_n is high have no effect.
- R2: In the first byte, bits 5..0 are the device address, bit 6 selects the channel (1 = X, 0 = Y) and bit 7 must be 0. If the address differs from strap_addr, or bit 7 is 1, no register changes for the rest of the transaction.
- R3: After an accepted first byte, the second byte is written whole into the selected channel's control register. The other channel's registers stay unchanged.
- R4: The third byte's bits 5..0 load the selected channel's input slot, and the fourth byte's bits 5..0 load its output slot. Bits 7..6 of both bytes are dropped. Bytes after the fourth are ignored. A transaction that ends after two bytes leaves both slot registers unchanged.
- R5: When cs_n rises, any partial byte is discarded. The next low period of cs_n starts again with an address byte.
- R6: upd_busy rises only after a complete, accepted address byte. It stays high until cs_n rises, then falls within four clk cycles. It stays low for transactions that are not accepted.
- R7: While rst_n is low (asynchronous), both control registers become 0x20, with bit 5 (idle) set and all other bits clear. All slot registers become 0 and upd_busy is low.
- R8: Control bit 4 (algorithm reset) stays set until that channel's alrst_done input is seen high. It then clears and leaves the other control bits unchanged. The other channel's done input has no effect on it.
- R9: While port_en is low, serial transactions change nothing, upd_busy stays low and all four slot outputs read 0. When port_en returns high, the stored slot values reappear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, faster than sclk |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_en | input | 1 | 1 = serial port active, 0 = hardware mode |
| sclk | input | 1 | Serial clock |
| sdi | input | 1 | Serial data, LSB first |
| cs_n | input | 1 | Active-low select |
| strap_addr | input | 6 | Device address straps |
| alrst_done_x | input | 1 | X channel reports algorithm reset complete |
| alrst_done_y | input | 1 | Y channel reports algorithm reset complete |
| ctrl_x | output | 8 | X control register |
| ctrl_y | output | 8 | Y control register |
| its_x | output | 6 | X input time slot |
| ots_x | output | 6 | X output time slot |
| its_y | output | 6 | Y input time slot |
| ots_y | output | 6 | Y output time slot |
| upd_busy | output | 1 | Request to tristate the data outputs during an update |

## Verification
The hardest case to reach from the ports is a select edge that lands partway through a byte, either before the address is complete or in the middle of the control byte after an accepted address. The stimulus raises cs_n after a chosen number of bits and then runs a clean transaction. This shows that the bit counter restarted and that no half-shifted value reached a register. A second hard case is the release of the self-clearing reset bit. The bench holds one channel's bit set, pulses the other channel's done input first and then its own, and watches that exactly one bit drops. Matching and non-matching addresses are covered by sweeping all 64 address values against fixed straps, and again with the straps following the address.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
    localparam int ADDR_W     = 6;
    localparam int BYTE_W     = 8;
    localparam int TS_W       = 6;
    localparam int CHAN_N     = 2;
    localparam int IDX_IDLE   = 5;
    localparam int IDX_ALRST  = 4;
    localparam int IDX_CHSEL  = 6;
    localparam int IDX_RSVD   = 7;
    localparam logic [BYTE_W-1:0] CTRL_RESET = 8'h20;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_CTRL,
        ST_ITS,
        ST_OTS,
        ST_DONE,
        ST_SKIP
    } cfg_state_e;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic sdi,
    input  logic cs_n,
    output logic bit_stb,
    output logic bit_val,
    output logic cs_act
);
    logic [STAGES-1:0] sclk_ff;
    logic [STAGES-1:0] sdi_ff;
    logic [STAGES-1:0] csn_ff;
    logic              sclk_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_ff   <= '0;
            sdi_ff    <= '0;
            csn_ff    <= '1;
            sclk_last <= 1'b0;
        end else begin
            sclk_ff   <= {sclk_ff[STAGES-2:0], sclk};
            sdi_ff    <= {sdi_ff[STAGES-2:0], sdi};
            csn_ff    <= {csn_ff[STAGES-2:0], cs_n};
            sclk_last <= sclk_ff[STAGES-1];
        end
    end

    always_comb begin
        cs_act  = ~csn_ff[STAGES-1];
        bit_stb = sclk_ff[STAGES-1] & ~sclk_last & cs_act;
        bit_val = sdi_ff[STAGES-1];
    end
endmodule

// File: rtl/cfg_shift.sv
module cfg_shift #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              bit_stb,
    input  logic              bit_val,
    output logic              byte_stb,
    output logic [BYTE_W-1:0] byte_val
);
    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

    logic [BYTE_W-1:0] sh;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] sh_next;

    always_comb sh_next = {bit_val, sh[BYTE_W-1:1]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh       <= '0;
            cnt      <= '0;
            byte_stb <= 1'b0;
            byte_val <= '0;
        end else if (!cs_act) begin
            cnt      <= '0;
            byte_stb <= 1'b0;
        end else if (bit_stb) begin
            sh <= sh_next;
            if (cnt == LAST) begin
                cnt      <= '0;
                byte_stb <= 1'b1;
                byte_val <= sh_next;
            end else begin
                cnt      <= cnt + 1'b1;
                byte_stb <= 1'b0;
            end
        end else begin
            byte_stb <= 1'b0;
        end
    end

    // R1: a byte completes only from bits taken while selected
    a_r1_byte_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
        byte_stb |-> $past(cs_act));

    // R5: a deselect restarts the bit count
    a_r5_restart_count: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> (cnt == '0) && !byte_stb);
endmodule

// File: rtl/cfg_fsm.sv
module cfg_fsm
    import cfgp_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int BW = BYTE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          port_en,
    input  logic          cs_act,
    input  logic          byte_stb,
    input  logic [BW-1:0] byte_val,
    input  logic [AW-1:0] strap_addr,
    output logic          busy,
    output logic          wr_ctrl,
    output logic          wr_its,
    output logic          wr_ots,
    output logic          wr_to_x,
    output logic [BW-1:0] wr_data
);
    cfg_state_e state, state_nx;
    logic       chan_x;
    logic       addr_ok;

    always_comb addr_ok = (byte_val[AW-1:0] == strap_addr) && !byte_val[IDX_RSVD];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            chan_x <= 1'b0;
        end else begin
            state <= state_nx;
            if (state == ST_ADDR && byte_stb && addr_ok)
                chan_x <= byte_val[IDX_CHSEL];
        end
    end

    always_comb begin
        state_nx = state;
        if (!port_en || !cs_act) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: state_nx = ST_ADDR;
                ST_ADDR: if (byte_stb) state_nx = addr_ok ? ST_CTRL : ST_SKIP;
                ST_CTRL: if (byte_stb) state_nx = ST_ITS;
                ST_ITS:  if (byte_stb) state_nx = ST_OTS;
                ST_OTS:  if (byte_stb) state_nx = ST_DONE;
                ST_DONE: state_nx = ST_DONE;
                ST_SKIP: state_nx = ST_SKIP;
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        busy    = 1'b0;
        wr_ctrl = 1'b0;
        wr_its  = 1'b0;
        wr_ots  = 1'b0;
        wr_to_x = chan_x;
        wr_data = byte_val;
        unique case (state)
            ST_CTRL: begin busy = 1'b1; wr_ctrl = byte_stb; end
            ST_ITS:  begin busy = 1'b1; wr_its  = byte_stb; end
            ST_OTS:  begin busy = 1'b1; wr_ots  = byte_stb; end
            ST_DONE: busy = 1'b1;
            default: busy = 1'b0;
        endcase
    end

    // R4: at most one register write per cycle
    a_r4_one_write: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_ctrl, wr_its, wr_ots}));

    // R6: busy starts only on a completed address byte
    a_r6_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(byte_stb));

    // R6: deselect ends busy
    a_r6_busy_end: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> !busy);

    // R9: hardware mode keeps the port idle
    a_r9_hw_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !port_en |=> !busy && !wr_ctrl);
endmodule

// File: rtl/cfg_chan_regs.sv
module cfg_chan_regs
    import cfgp_pkg::*;
#(
    parameter int BW = BYTE_W,
    parameter int TW = TS_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_ctrl,
    input  logic          wr_its,
    input  logic          wr_ots,
    input  logic [BW-1:0] wr_data,
    input  logic          alrst_done,
    output logic [BW-1:0] ctrl,
    output logic [TW-1:0] its,
    output logic [TW-1:0] ots
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl <= CTRL_RESET;
            its  <= '0;
            ots  <= '0;
        end else begin
            if (wr_ctrl)
                ctrl <= wr_data;
            else if (alrst_done && ctrl[IDX_ALRST])
                ctrl[IDX_ALRST] <= 1'b0;
            if (wr_its) its <= wr_data[TW-1:0];
            if (wr_ots) ots <= wr_data[TW-1:0];
        end
    end

    // R8: the reset bit drops only on done or a fresh write
    a_r8_alrst_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctrl[IDX_ALRST]) |-> ($past(alrst_done) || $past(wr_ctrl)));

    // R4: slot registers hold without a write
    a_r4_its_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_its |=> $stable(its));
    a_r4_ots_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ots |=> $stable(ots));
endmodule

// File: rtl/cfg_port.sv
module cfg_port
    import cfgp_pkg::*;
#(
    parameter int AW     = ADDR_W,
    parameter int BW     = BYTE_W,
    parameter int TW     = TS_W,
    parameter int STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          port_en,
    input  logic          sclk,
    input  logic          sdi,
    input  logic          cs_n,
    input  logic [AW-1:0] strap_addr,
    input  logic          alrst_done_x,
    input  logic          alrst_done_y,
    output logic [BW-1:0] ctrl_x,
    output logic [BW-1:0] ctrl_y,
    output logic [TW-1:0] its_x,
    output logic [TW-1:0] ots_x,
    output logic [TW-1:0] its_y,
    output logic [TW-1:0] ots_y,
    output logic          upd_busy
);
    logic          bit_stb, bit_val, cs_act;
    logic          byte_stb;
    logic [BW-1:0] byte_val;
    logic          wr_ctrl, wr_its, wr_ots, wr_to_x;
    logic [BW-1:0] wr_data;
    logic [CHAN_N-1:0] done_vec;
    logic [BW-1:0] ctrl_q [CHAN_N];
    logic [TW-1:0] its_q  [CHAN_N];
    logic [TW-1:0] ots_q  [CHAN_N];

    cfg_sync #(.STAGES(STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdi(sdi), .cs_n(cs_n),
        .bit_stb(bit_stb), .bit_val(bit_val), .cs_act(cs_act)
    );

    cfg_shift #(.BYTE_W(BW)) u_shift (
        .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .bit_stb(bit_stb),
        .bit_val(bit_val), .byte_stb(byte_stb), .byte_val(byte_val)
    );

    cfg_fsm #(.AW(AW), .BW(BW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .port_en(port_en), .cs_act(cs_act),
        .byte_stb(byte_stb), .byte_val(byte_val), .strap_addr(strap_addr),
        .busy(upd_busy), .wr_ctrl(wr_ctrl), .wr_its(wr_its), .wr_ots(wr_ots),
        .wr_to_x(wr_to_x), .wr_data(wr_data)
    );

    always_comb done_vec = {alrst_done_x, alrst_done_y};

    for (genvar g = 0; g < CHAN_N; g++) begin : g_chan
        localparam logic IS_X = (g == 1);
        logic sel;
        always_comb sel = (wr_to_x == IS_X);
        cfg_chan_regs #(.BW(BW), .TW(TW)) u_regs (
            .clk(clk), .rst_n(rst_n),
            .wr_ctrl(wr_ctrl && sel), .wr_its(wr_its && sel), .wr_ots(wr_ots && sel),
            .wr_data(wr_data), .alrst_done(done_vec[g]),
            .ctrl(ctrl_q[g]), .its(its_q[g]), .ots(ots_q[g])
        );
    end

    always_comb begin
        ctrl_y = ctrl_q[0];
        ctrl_x = ctrl_q[1];
        its_y  = port_en ? its_q[0] : '0;
        ots_y  = port_en ? ots_q[0] : '0;
        its_x  = port_en ? its_q[1] : '0;
        ots_x  = port_en ? ots_q[1] : '0;
    end

    // R7: control registers leave reset with the idle bit set
    a_r7_reset_idle: assert property (@(posedge clk)
        !rst_n |=> ctrl_x[IDX_IDLE] && ctrl_y[IDX_IDLE]);
endmodule

// File: tb/cfg_port_bench.sv
module cfg_port_bench;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_BIT   = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       port_en = 1'b1;
    logic       sclk = 1'b0;
    logic       sdi = 1'b0;
    logic       cs_n = 1'b1;
    logic [5:0] strap_addr = 6'h2B;
    logic       alrst_done_x = 1'b0;
    logic       alrst_done_y = 1'b0;
    logic [7:0] ctrl_x, ctrl_y;
    logic [5:0] its_x, ots_x, its_y, ots_y;
    logic       upd_busy;

    int errors = 0;
    int checks = 0;
    logic [7:0] e_ctrl [2];
    logic [5:0] e_its  [2];
    logic [5:0] e_ots  [2];

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_port u_cfg_port (
        .clk(clk), .rst_n(rst_n), .port_en(port_en), .sclk(sclk), .sdi(sdi),
        .cs_n(cs_n), .strap_addr(strap_addr), .alrst_done_x(alrst_done_x),
        .alrst_done_y(alrst_done_y), .ctrl_x(ctrl_x), .ctrl_y(ctrl_y),
        .its_x(its_x), .ots_x(ots_x), .its_y(its_y), .ots_y(ots_y),
        .upd_busy(upd_busy)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        sdi = b;
        wait_clk(HALF_BIT);
        sclk = 1'b1;
        wait_clk(HALF_BIT);
        sclk = 1'b0;
        wait_clk(2);
    endtask

    task automatic send_bits(input logic [7:0] v, input int n);
        for (int i = 0; i < n; i++) send_bit(v[i]);
    endtask

    task automatic start_tx();
        cs_n = 1'b0;
        wait_clk(4);
    endtask

    task automatic stop_tx();
        wait_clk(4);
        cs_n = 1'b1;
        wait_clk(8);
    endtask

    task automatic check_all(input string tag);
        chk({tag, " ctrl_x"}, 32'(ctrl_x), 32'(e_ctrl[1]));
        chk({tag, " ctrl_y"}, 32'(ctrl_y), 32'(e_ctrl[0]));
        chk({tag, " its_x"}, 32'(its_x), 32'(port_en ? e_its[1] : 6'd0));
        chk({tag, " ots_x"}, 32'(ots_x), 32'(port_en ? e_ots[1] : 6'd0));
        chk({tag, " its_y"}, 32'(its_y), 32'(port_en ? e_its[0] : 6'd0));
        chk({tag, " ots_y"}, 32'(ots_y), 32'(port_en ? e_ots[0] : 6'd0));
    endtask

    task automatic model_reset();
        for (int c = 0; c < 2; c++) begin
            e_ctrl[c] = 8'h20;
            e_its[c]  = 6'd0;
            e_ots[c]  = 6'd0;
        end
    endtask

    // nbytes: 1..5 bytes after cs_n falls; model updates when accepted
    task automatic txn(input string tag, input logic [7:0] ab, input logic [7:0] cb,
                       input logic [7:0] ib, input logic [7:0] ob, input int nbytes);
        logic ok;
        int   c;
        ok = port_en && (ab[5:0] == strap_addr) && !ab[7];
        c  = ab[6] ? 1 : 0;
        start_tx();
        send_bits(ab, 8);
        chk({tag, " R6 busy after address"}, 32'(upd_busy), 32'(ok));
        if (nbytes >= 2) begin send_bits(cb, 8); if (ok) e_ctrl[c] = cb; end
        if (nbytes >= 3) begin send_bits(ib, 8); if (ok) e_its[c] = ib[5:0]; end
        if (nbytes >= 4) begin send_bits(ob, 8); if (ok) e_ots[c] = ob[5:0]; end
        if (nbytes >= 5) send_bits(8'hFF, 8);
        stop_tx();
        chk({tag, " R6 busy after deselect"}, 32'(upd_busy), 32'(0));
        check_all(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        model_reset();
        wait_clk(3);
        // R7: reset state
        check_all("R7 reset");
        chk("R7 reset busy", 32'(upd_busy), 32'(0));
        rst_n = 1'b1;
        wait_clk(3);
        check_all("R7 after release");

        // R2 sweep all addresses against fixed straps (R1 LSB-first bytes)
        for (int a = 0; a < 64; a++) begin
            txn("R2 sweep fixed strap", {1'b0, a[0], 6'(a)}, 8'(a*37+5) & 8'hEF,
                8'(a*7+3), 8'(a*11+1), 4);
        end

        // R3 R4 sweep with straps following the address
        for (int a = 0; a < 64; a++) begin
            strap_addr = 6'(a);
            txn("R3 R4 sweep matching", {1'b0, a[1], 6'(a)}, 8'(a*53+9) & 8'hEF,
                8'(a*13+200), 8'(a*29+77), 4);
        end
        strap_addr = 6'h15;

        // R4: two-byte write keeps slots
        txn("R4 two byte", 8'h55, 8'h8C, 8'h00, 8'h00, 2);
        // R4: extra byte ignored
        txn("R4 five byte", 8'h15, 8'h03, 8'hC7, 8'h81, 5);
        // R2: reserved bit set ignored
        txn("R2 reserved bit", 8'hD5, 8'hFF, 8'h3F, 8'h3F, 4);
        // R2: wrong address
        txn("R2 mismatch", 8'h56, 8'h00, 8'h11, 8'h22, 4);

        // R5: partial address byte then clean transaction
        start_tx();
        send_bits(8'h55, 3);
        stop_tx();
        chk("R5 partial address busy", 32'(upd_busy), 32'(0));
        txn("R5 restart", 8'h55, 8'h41, 8'h05, 8'h06, 4);

        // R5: address accepted, control byte cut short
        start_tx();
        send_bits(8'h55, 8);
        send_bits(8'hAA, 5);
        stop_tx();
        check_all("R5 partial control");

        // R1: sclk edges with cs_n high are ignored
        for (int i = 0; i < 8; i++) send_bit(1'b1);
        txn("R1 idle edges", 8'h15, 8'h0A, 8'h09, 8'h08, 4);

        // R8: algorithm reset bit self clear
        txn("R8 set alrst", 8'h55, 8'h95, 8'h01, 8'h02, 2);
        wait_clk(10);
        chk("R8 held without done", 32'(ctrl_x), 32'(8'h95));
        alrst_done_y = 1'b1;
        wait_clk(1);
        alrst_done_y = 1'b0;
        wait_clk(2);
        chk("R8 other done ignored", 32'(ctrl_x), 32'(8'h95));
        alrst_done_x = 1'b1;
        wait_clk(1);
        alrst_done_x = 1'b0;
        wait_clk(2);
        e_ctrl[1] = 8'h85;
        chk("R8 cleared by done", 32'(ctrl_x), 32'(8'h85));
        check_all("R8 rest");

        // R9: hardware mode
        port_en = 1'b0;
        wait_clk(3);
        check_all("R9 slots forced zero");
        txn("R9 port disabled", 8'h55, 8'h00, 8'h2A, 8'h2A, 4);
        port_en = 1'b1;
        wait_clk(3);
        check_all("R9 slots restored");

        // R7: reset again clears everything
        rst_n = 1'b0;
        model_reset();
        wait_clk(2);
        check_all("R7 second reset");
        rst_n = 1'b1;
        wait_clk(3);
        txn("R7 after second reset", 8'h15, 8'h10, 8'h3F, 8'h00, 4);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule